// File: doc/BRIEF.md
# Asymmetric-Phase Converter Clock Divider

This block derives a slow sampling clock for an analog-to-digital converter from the system clock. The high and the low portions of each output period are set independently. A 5-bit setting gives the number of system clocks in the high portion, minus one. A 3-bit setting gives the number of system clocks in the low portion, minus one. Setting them separately lets software reach a duty cycle close to 50% for many division ratios, or keep the high portion long when the ratio is large.

A single down counter times both portions. It is loaded with the high setting when a high portion begins and is decremented on every system clock. A zero detect ends the high portion. The counter then keeps counting through its wrap to all ones. The low portion ends when the counter's three least significant bits equal the bitwise inverse of the low setting. New settings take effect only when a high portion begins, so a change written mid-period never shortens a portion. Each transition of the output also produces a one-cycle strobe for downstream sampling logic.

The design has no data stream. Every pin is a plain control or status signal, so there is no valid/ready handshake and no back-pressure.

Top module: `adc_clk_prescaler`

## Requirements
- R1: The timing counter is loaded with the high setting on the edge that starts a high portion. It then decrements by one on every system clock while running. After reaching zero it wraps to all ones and keeps decrementing.
- R2: Each high portion of `div_clk` lasts exactly `cfg_high`+1 system clocks (1 to 32). It ends on the edge after the counter reads zero.
- R3: Each low portion lasts exactly `cfg_low`+1 system clocks (1 to 8). It ends when counter bits [2:0] equal the bitwise inverse of the low setting: 3'b111 for a setting of 0, 3'b000 for a setting of 7.
- R4: While enabled, high and low portions follow each other with no idle cycle, so the output period is `cfg_high`+`cfg_low`+2 system clocks.
- R5: Both settings are captured only on the edge that starts a high portion. A change during a period takes effect from the next high portion.
- R6: `cfg_legacy_add` has no effect on `div_clk` or the strobes.
- R7: While `enable` is low, `div_clk` is low from the next edge on and the counter holds. The first edge with `enable` high after an idle spell starts a full high portion.
- R8: While `rst_n` is low, `div_clk`, `rise_stb` and `fall_stb` are low. The first edge after release with `enable` high starts a full high portion.
- R9: `rise_stb` is high for exactly the first system clock in which `div_clk` is high. `fall_stb` is high for exactly the first system clock in which `div_clk` is low after a high portion. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the divider when high |
| cfg_high | input | 5 | High portion length minus one |
| cfg_low | input | 3 | Low portion length minus one |
| cfg_legacy_add | input | 1 | Compatibility control bit, ignored |
| div_clk | output | 1 | Divided converter clock |
| rise_stb | output | 1 | One-cycle pulse in the first high cycle |
| fall_stb | output | 1 | One-cycle pulse in the first low cycle |

## Verification
On every cycle, the assertions check the following:
- the counter wraps from zero to all ones;
- each high or low portion ends after exactly its captured setting plus one cycles;
- the output falls on the edge after `enable` drops;
- the strobes are never high together, and each agrees with the output level.

Only the bench scenarios can show the remaining behaviours. These are that the lengths match the values applied at the ports for every pair of settings, that a mid-period write is deferred, that the legacy bit is ignored, and that a fresh high portion follows idle and reset.

// File: rtl/adcp_pkg.sv
package adcp_pkg;
  localparam int HI_W_DEF = 5;
  localparam int LO_W_DEF = 3;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } adcp_phase_e;
endpackage

// File: rtl/adcp_phase_timer.sv
module adcp_phase_timer #(
  parameter int HI_W = adcp_pkg::HI_W_DEF,
  parameter int LO_W = adcp_pkg::LO_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [HI_W-1:0] load_val,
  input  logic            hold,
  input  logic [LO_W-1:0] low_cfg,
  output logic            zero_hit,
  output logic            low_match
);
  logic [HI_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= load_val;
    else if (!hold)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_hit  = (cnt_q == '0);
  assign low_match = (cnt_q[LO_W-1:0] == ~low_cfg);

  // R1: counting continues through zero into the all-ones value
  a_r1_wrap_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !hold && cnt_q == '0) |=> (cnt_q == '1));
endmodule

// File: rtl/adcp_phase_ctrl.sv
module adcp_phase_ctrl #(
  parameter int HI_W = adcp_pkg::HI_W_DEF,
  parameter int LO_W = adcp_pkg::LO_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [HI_W-1:0] cfg_high,
  input  logic [LO_W-1:0] cfg_low,
  input  logic            zero_hit,
  input  logic            low_match,
  output logic            load,
  output logic            hold,
  output logic [LO_W-1:0] low_cfg,
  output logic            div_clk,
  output logic            rise_stb,
  output logic            fall_stb
);
  import adcp_pkg::*;
  localparam int LW = HI_W + 1;

  adcp_phase_e     st_q, st_d;
  logic [LO_W-1:0] psl_q;
  logic [HI_W-1:0] psh_q;
  logic            rise_q, fall_q;
  logic [LW-1:0]   len_q;

  always_comb begin
    st_d = st_q;
    load = 1'b0;
    unique case (st_q)
      PH_IDLE: if (enable) begin st_d = PH_HIGH; load = 1'b1; end
      PH_HIGH: if (!enable) st_d = PH_IDLE;
               else if (zero_hit) st_d = PH_LOW;
      PH_LOW:  if (!enable) st_d = PH_IDLE;
               else if (low_match) begin st_d = PH_HIGH; load = 1'b1; end
      default: st_d = PH_IDLE;
    endcase
  end

  assign hold = (st_q == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      psl_q  <= '0;
      psh_q  <= '0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      rise_q <= (st_q != PH_HIGH) && (st_d == PH_HIGH);
      fall_q <= (st_q == PH_HIGH) && (st_d != PH_HIGH);
      if (load) begin
        psl_q <= cfg_low;
        psh_q <= cfg_high;
      end
    end
  end

  // length of the current level, used by the phase-length checks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             len_q <= '0;
    else if (st_d != st_q)  len_q <= LW'(1);
    else if (len_q != '1)   len_q <= len_q + 1'b1;
  end

  assign low_cfg  = psl_q;
  assign div_clk  = (st_q == PH_HIGH);
  assign rise_stb = rise_q;
  assign fall_stb = fall_q;

  a_r2_high_len: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_HIGH && enable && zero_hit) |-> (len_q == LW'(psh_q) + LW'(1)));
  a_r3_low_len: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PH_LOW && enable && low_match) |-> (len_q == LW'(psl_q) + LW'(1)));
  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !div_clk);
  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));
  a_r9_rise_level: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |-> div_clk);
  a_r9_fall_level: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |-> !div_clk);
endmodule

// File: rtl/adc_clk_prescaler.sv
module adc_clk_prescaler #(
  parameter int HI_W = adcp_pkg::HI_W_DEF,
  parameter int LO_W = adcp_pkg::LO_W_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic [HI_W-1:0] cfg_high,
  input  logic [LO_W-1:0] cfg_low,
  input  logic            cfg_legacy_add,
  output logic            div_clk,
  output logic            rise_stb,
  output logic            fall_stb
);
  logic            load, hold, zero_hit, low_match;
  logic [LO_W-1:0] low_cfg;

  // R6: accepted for compatibility, deliberately left unconnected
  logic unused_legacy;
  assign unused_legacy = cfg_legacy_add;

  adcp_phase_ctrl #(.HI_W(HI_W), .LO_W(LO_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_high(cfg_high), .cfg_low(cfg_low),
    .zero_hit(zero_hit), .low_match(low_match),
    .load(load), .hold(hold), .low_cfg(low_cfg),
    .div_clk(div_clk), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  adcp_phase_timer #(.HI_W(HI_W), .LO_W(LO_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(cfg_high),
    .hold(hold), .low_cfg(low_cfg),
    .zero_hit(zero_hit), .low_match(low_match)
  );
endmodule

// File: tb/adc_clk_prescaler_tb_top.sv
module adc_clk_prescaler_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [4:0] cfg_high = '0;
  logic [2:0] cfg_low = '0;
  logic cfg_legacy_add = 1'b0;
  logic div_clk, rise_stb, fall_stb;
  int vecs = 0;
  int miss = 0;

  always #4 clk = ~clk;

  adc_clk_prescaler dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_high(cfg_high), .cfg_low(cfg_low), .cfg_legacy_add(cfg_legacy_add),
    .div_clk(div_clk), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      miss++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // entered at the first high sample; leaves at the first high sample of the next period
  task automatic meas(output int hi, output int lo, output bit rs_ok, output bit fs_ok);
    hi = 0; lo = 0;
    rs_ok = rise_stb;
    while (div_clk && hi < 100) begin
      hi++;
      if (hi > 1 && rise_stb) rs_ok = 1'b0;
      @(negedge clk);
    end
    fs_ok = fall_stb;
    while (!div_clk && lo < 100) begin
      lo++;
      if (lo > 1 && fall_stb) fs_ok = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    miss++;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    int h, l;
    bit rs, fs;
    // R8: reset state
    repeat (3) @(negedge clk);
    chk(!div_clk && !rise_stb && !fall_stb, "R8 reset outputs", int'(div_clk), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R9: full sweep of both settings, legacy bit varied
    for (int ph = 0; ph < 32; ph++) begin
      for (int pl = 0; pl < 8; pl++) begin
        enable = 1'b0;
        cfg_high = 5'(ph);
        cfg_low = 3'(pl);
        cfg_legacy_add = 1'((ph + pl) % 2);
        repeat (2) @(negedge clk);
        chk(!div_clk, "R7 idle low", int'(div_clk), 0);
        enable = 1'b1;
        @(negedge clk);
        chk(div_clk, "R7 start high", int'(div_clk), 1);
        meas(h, l, rs, fs);
        chk(h == ph + 1, "R2 high length (R1 load)", h, ph + 1);
        chk(l == pl + 1, "R3 low length (R1 wrap)", l, pl + 1);
        chk(rs, "R9 rise strobe", int'(rs), 1);
        chk(fs, "R9 fall strobe", int'(fs), 1);
        meas(h, l, rs, fs);
        chk(h + l == ph + pl + 2, "R4 period", h + l, ph + pl + 2);
      end
    end

    // R6: legacy bit set versus clear gives the same waveform
    for (int lg = 0; lg < 2; lg++) begin
      enable = 1'b0; cfg_high = 5'd11; cfg_low = 3'd7; cfg_legacy_add = 1'(lg);
      repeat (2) @(negedge clk);
      enable = 1'b1;
      @(negedge clk);
      meas(h, l, rs, fs);
      chk(h == 12 && l == 8 && rs && fs, "R6 legacy ignored high", h, 12);
      chk(l == 8, "R6 legacy ignored low", l, 8);
    end

    // R5: write during a high portion is deferred to the next period
    enable = 1'b0; cfg_high = 5'd3; cfg_low = 3'd2; cfg_legacy_add = 1'b0;
    repeat (2) @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cfg_high = 5'd9; cfg_low = 3'd5;
    meas(h, l, rs, fs);
    chk(h == 3, "R5 current high kept", h, 3);
    chk(l == 3, "R5 current low kept", l, 3);
    meas(h, l, rs, fs);
    chk(h == 10, "R5 new high applied", h, 10);
    chk(l == 6, "R5 new low applied", l, 6);

    // R7 R9: enable dropped mid high portion
    cfg_high = 5'd5; cfg_low = 3'd3;
    repeat (3) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(!div_clk, "R7 low after disable", int'(div_clk), 0);
    chk(fall_stb, "R9 fall on disable", int'(fall_stb), 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!div_clk && !rise_stb, "R7 stays low", int'(div_clk), 0);
    end
    enable = 1'b1;
    @(negedge clk);
    chk(div_clk && rise_stb, "R7 restart high", int'(div_clk), 1);
    meas(h, l, rs, fs);
    chk(h == 6, "R7 full high after idle", h, 6);

    // R8: reset while running, then fresh high portion
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!div_clk && !rise_stb && !fall_stb, "R8 reset forces low", int'(div_clk), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(div_clk, "R8 high after release", int'(div_clk), 1);
    meas(h, l, rs, fs);
    chk(h == 6, "R8 full high after release", h, 6);
    chk(l == 4, "R8 low after release", l, 4);

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule